// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block is the control engine of an I2C master. Software-style register inputs choose the direction, the address width, whether the bus is kept after the transfer, a 10-bit target address and a byte count. Writing the address starts a transfer. The sequencer then issues one command at a time to a byte-level bit engine: start condition, byte write, byte read, or stop condition. Each command ends with a single done pulse from that engine. Data bytes move between a 16-entry transmit FIFO and a 16-entry receive FIFO.

A down-counter loaded with the transfer size decides when the data phase ends. When the count runs out the block raises a completion event. It then either sends a stop condition or keeps the bus for a repeated start. A NACK from the target or a lost arbitration, both reported by the bit engine, ends the transfer early and raises its own event. A status word reports the bus-active flag and the receive-data-valid flag.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, statusWord is zero, cmdValid is low, sizeLeft is zero and every event output is low. In statusWord, bit 8 is bus-active, bit 5 is receive-data-valid, and all other bits are zero.
- R2: A transfer starts only when addrWrEn is asserted while cfgMaster is 1 and the sequencer is idle or holding the bus. An address write at any other time issues no command and leaves any running transfer unchanged.
- R3: Commands appear on cmdKind as 0 start, 1 write, 2 read and 3 stop. With cfgAddr7 set, a transfer begins with a start, then a write of {addr[6:0], dir}, where dir is cfgDirRx (0 transmit, 1 receive).
- R4: With cfgAddr7 clear, a transfer sends a start, a write of {5'b11110, addr[9:8], 0} and a write of addr[7:0]. In receive mode it then sends a second start and a write of {5'b11110, addr[9:8], 1}.
- R5: In transmit mode, bytes are written in FIFO order. Each acknowledged byte leaves the transmit FIFO and decrements sizeLeft by one. No write is issued while the transmit FIFO is empty.
- R6: In receive mode, a read is issued only while the receive FIFO holds fewer than 16 bytes. Received bytes are delivered in arrival order on rxRdData. cmdNack is 1 only on the read issued when sizeLeft is 1.
- R7: evtData pulses for one cycle when a push brings the receive FIFO to 14 entries.
- R8: evtComplete pulses once when sizeLeft reaches zero in the data phase, including directly after the address for a size of zero.
- R9: After completion with cfgHold clear, a stop is issued and bus-active drops. With cfgHold set, no stop is issued and bus-active stays 1. The next address write then opens with a start, which is a repeated start.
- R10: A NACK on any written byte pulses evtNack, issues a stop and gives no completion. A refused data byte stays in the transmit FIFO, and sizeLeft keeps its value.
- R11: Arbitration loss reported with a done pulse raises evtArbLost and issues no further command, including no stop. Bus-active clears, and the transmit FIFO and sizeLeft are unchanged.
- R12: A pulse on clrFifo empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMaster | input | 1 | Master mode enable |
| cfgDirRx | input | 1 | 0 transmit, 1 receive |
| cfgHold | input | 1 | Keep bus after completion |
| cfgAddr7 | input | 1 | 1 selects 7-bit addressing |
| clrFifo | input | 1 | Empty both FIFOs |
| addrWrEn | input | 1 | Address write, starts a transfer |
| addrWrData | input | 10 | Target address |
| sizeWrEn | input | 1 | Load transfer size |
| sizeWrData | input | 8 | Transfer size in bytes |
| txWrEn | input | 1 | Push into transmit FIFO |
| txWrData | input | 8 | Transmit byte |
| rxRdEn | input | 1 | Pop from receive FIFO |
| rxRdData | output | 8 | Head of receive FIFO |
| cmdValid | output | 1 | One-cycle command strobe to bit engine |
| cmdKind | output | 2 | Command code |
| cmdByte | output | 8 | Byte for a write command |
| cmdNack | output | 1 | Answer NACK after this read |
| engDone | input | 1 | Bit engine finished the command |
| engNack | input | 1 | Written byte was not acknowledged |
| engArbLost | input | 1 | Arbitration lost during the command |
| engRxByte | input | 8 | Byte received by a read command |
| statusWord | output | 16 | Status flags |
| sizeLeft | output | 8 | Remaining byte count |
| evtComplete | output | 1 | Completion event |
| evtData | output | 1 | Receive threshold event |
| evtNack | output | 1 | NACK event |
| evtArbLost | output | 1 | Arbitration-lost event |

## Verification
A command strobe appears one cycle after the edge on which the sequencer enters, or returns to, a phase that can issue. Received bytes, the receive-data-valid flag and evtData change on the edge that takes the done pulse. Events other than evtData also follow that edge by one register stage. evtComplete comes one further cycle later, when the counter is seen to be zero. The bench drives inputs and the bit-engine model on the falling edge. It updates its queue model of the receive FIFO on the rising edge and compares rxRdData, receive-data-valid and evtData on every falling edge. It checks command sequences, counts and bus state only after the bus has settled.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int ADDR_W    = 10;
  localparam int STATUS_W  = 16;
  localparam int BUSY_BIT  = 8;
  localparam int RXV_BIT   = 5;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_STOP  = 2'd3
  } cmdKind_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_HDR, PH_LOW, PH_RSTART,
    PH_HDR_RD, PH_DATA, PH_STOP, PH_HELD
  } phase_t;

  typedef struct packed {
    logic txPop;
    logic rxPush;
  } dpStrobe_t;

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 pushData,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic          doPush, doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign doPush = push && (level != LW'(DEPTH));
  assign doPop  = pop && (level != '0);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int THRESH = 14
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clrFifo,
  input  logic                       txWrEn,
  input  logic [DATA_W-1:0]          txWrData,
  input  logic                       rxRdEn,
  input  dpStrobe_t                  strobe,
  input  logic [DATA_W-1:0]          rxByteIn,
  output logic [DATA_W-1:0]          txHead,
  output logic                       txEmpty,
  output logic [DATA_W-1:0]          rxHead,
  output logic                       rxFull,
  output logic                       rxValid,
  output logic [$clog2(DEPTH+1)-1:0] rxLevel,
  output logic                       evtData
);
  localparam int LW = $clog2(DEPTH+1);

  logic [LW-1:0] txLevel;
  logic          rxPopEff;

  seq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .clr(clrFifo),
    .push(txWrEn), .pushData(txWrData), .pop(strobe.txPop),
    .head(txHead), .level(txLevel)
  );

  seq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .clr(clrFifo),
    .push(strobe.rxPush), .pushData(rxByteIn), .pop(rxRdEn),
    .head(rxHead), .level(rxLevel)
  );

  assign txEmpty  = (txLevel == '0);
  assign rxFull   = (rxLevel == LW'(DEPTH));
  assign rxValid  = (rxLevel != '0);
  assign rxPopEff = rxRdEn && rxValid;

  always_ff @(posedge clk) begin
    if (!rstN) evtData <= 1'b0;
    else evtData <= !clrFifo && strobe.rxPush && !rxPopEff &&
                    (rxLevel == LW'(THRESH - 1));
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMaster,
  input  logic              cfgDirRx,
  input  logic              cfgHold,
  input  logic              cfgAddr7,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              sizeWrEn,
  input  logic [CNT_W-1:0]  sizeWrData,
  input  logic [DATA_W-1:0] txHead,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              engDone,
  input  logic              engNack,
  input  logic              engArbLost,
  output dpStrobe_t         strobe,
  output logic              cmdValid,
  output cmdKind_t          cmdKind,
  output logic [DATA_W-1:0] cmdByte,
  output logic              cmdNack,
  output logic [CNT_W-1:0]  sizeLeft,
  output logic              busActive,
  output logic              evtComplete,
  output logic              evtNack,
  output logic              evtArbLost
);
  phase_t            phase;
  logic              waiting;
  logic [ADDR_W-1:0] addrQ;
  logic              dirRxQ, addr7Q;
  logic              startReq, dataDone, byteOk;
  logic [DATA_W-1:0] hdrByte, hdrRdByte;

  assign startReq  = addrWrEn && cfgMaster && (phase == PH_IDLE || phase == PH_HELD);
  assign dataDone  = waiting && engDone && !engArbLost && (phase == PH_DATA);
  assign strobe.txPop  = dataDone && !dirRxQ && !engNack;
  assign strobe.rxPush = dataDone && dirRxQ;
  assign byteOk    = strobe.txPop || strobe.rxPush;
  assign busActive = (phase != PH_IDLE);

  assign hdrByte   = addr7Q ? {addrQ[6:0], dirRxQ} : {TEN_PREFIX, addrQ[9:8], 1'b0};
  assign hdrRdByte = {TEN_PREFIX, addrQ[9:8], 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN)         sizeLeft <= '0;
    else if (sizeWrEn) sizeLeft <= sizeWrData;
    else if (byteOk)   sizeLeft <= sizeLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      waiting     <= 1'b0;
      addrQ       <= '0;
      dirRxQ      <= 1'b0;
      addr7Q      <= 1'b0;
      cmdValid    <= 1'b0;
      cmdKind     <= CMD_START;
      cmdByte     <= '0;
      cmdNack     <= 1'b0;
      evtComplete <= 1'b0;
      evtNack     <= 1'b0;
      evtArbLost  <= 1'b0;
    end else begin
      cmdValid    <= 1'b0;
      evtComplete <= 1'b0;
      evtNack     <= 1'b0;
      evtArbLost  <= 1'b0;
      if (startReq) begin
        addrQ   <= addrWrData;
        dirRxQ  <= cfgDirRx;
        addr7Q  <= cfgAddr7;
        phase   <= PH_START;
        waiting <= 1'b0;
      end else if (waiting) begin
        if (engDone) begin
          waiting <= 1'b0;
          if (engArbLost) begin
            evtArbLost <= 1'b1;
            phase      <= PH_IDLE;
          end else begin
            unique case (phase)
              PH_START:  phase <= PH_HDR;
              PH_RSTART: phase <= PH_HDR_RD;
              PH_HDR: begin
                if (engNack) begin
                  evtNack <= 1'b1;
                  phase   <= PH_STOP;
                end else phase <= addr7Q ? PH_DATA : PH_LOW;
              end
              PH_LOW: begin
                if (engNack) begin
                  evtNack <= 1'b1;
                  phase   <= PH_STOP;
                end else phase <= dirRxQ ? PH_RSTART : PH_DATA;
              end
              PH_HDR_RD: begin
                if (engNack) begin
                  evtNack <= 1'b1;
                  phase   <= PH_STOP;
                end else phase <= PH_DATA;
              end
              PH_DATA: begin
                if (!dirRxQ && engNack) begin
                  evtNack <= 1'b1;
                  phase   <= PH_STOP;
                end
              end
              PH_STOP: phase <= PH_IDLE;
              default: phase <= phase;
            endcase
          end
        end
      end else begin
        unique case (phase)
          PH_START, PH_RSTART: begin
            cmdValid <= 1'b1;
            cmdKind  <= CMD_START;
            cmdNack  <= 1'b0;
            waiting  <= 1'b1;
          end
          PH_HDR, PH_LOW, PH_HDR_RD: begin
            cmdValid <= 1'b1;
            cmdKind  <= CMD_WRITE;
            cmdNack  <= 1'b0;
            cmdByte  <= (phase == PH_HDR) ? hdrByte :
                        (phase == PH_LOW) ? addrQ[7:0] : hdrRdByte;
            waiting  <= 1'b1;
          end
          PH_DATA: begin
            if (sizeLeft == '0) begin
              evtComplete <= 1'b1;
              phase       <= cfgHold ? PH_HELD : PH_STOP;
            end else if (dirRxQ && !rxFull) begin
              cmdValid <= 1'b1;
              cmdKind  <= CMD_READ;
              cmdNack  <= (sizeLeft == CNT_W'(1));
              waiting  <= 1'b1;
            end else if (!dirRxQ && !txEmpty) begin
              cmdValid <= 1'b1;
              cmdKind  <= CMD_WRITE;
              cmdByte  <= txHead;
              cmdNack  <= 1'b0;
              waiting  <= 1'b1;
            end
          end
          PH_STOP: begin
            cmdValid <= 1'b1;
            cmdKind  <= CMD_STOP;
            cmdNack  <= 1'b0;
            waiting  <= 1'b1;
          end
          default: phase <= phase;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int DATA_THRESH = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgMaster,
  input  logic                cfgDirRx,
  input  logic                cfgHold,
  input  logic                cfgAddr7,
  input  logic                clrFifo,
  input  logic                addrWrEn,
  input  logic [ADDR_W-1:0]   addrWrData,
  input  logic                sizeWrEn,
  input  logic [CNT_W-1:0]    sizeWrData,
  input  logic                txWrEn,
  input  logic [DATA_W-1:0]   txWrData,
  input  logic                rxRdEn,
  output logic [DATA_W-1:0]   rxRdData,
  output logic                cmdValid,
  output logic [1:0]          cmdKind,
  output logic [DATA_W-1:0]   cmdByte,
  output logic                cmdNack,
  input  logic                engDone,
  input  logic                engNack,
  input  logic                engArbLost,
  input  logic [DATA_W-1:0]   engRxByte,
  output logic [STATUS_W-1:0] statusWord,
  output logic [CNT_W-1:0]    sizeLeft,
  output logic                evtComplete,
  output logic                evtData,
  output logic                evtNack,
  output logic                evtArbLost
);
  localparam int LW = $clog2(FIFO_DEPTH+1);

  dpStrobe_t         strobe;
  cmdKind_t          cmdKindE;
  logic [DATA_W-1:0] txHead;
  logic              txEmpty, rxFull, rxValid, busActive;
  logic [LW-1:0]     rxLevel;

  seq_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgMaster(cfgMaster), .cfgDirRx(cfgDirRx), .cfgHold(cfgHold), .cfgAddr7(cfgAddr7),
    .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .sizeWrEn(sizeWrEn), .sizeWrData(sizeWrData),
    .txHead(txHead), .txEmpty(txEmpty), .rxFull(rxFull),
    .engDone(engDone), .engNack(engNack), .engArbLost(engArbLost),
    .strobe(strobe), .cmdValid(cmdValid), .cmdKind(cmdKindE),
    .cmdByte(cmdByte), .cmdNack(cmdNack), .sizeLeft(sizeLeft),
    .busActive(busActive), .evtComplete(evtComplete),
    .evtNack(evtNack), .evtArbLost(evtArbLost)
  );

  seq_datapath #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .THRESH(DATA_THRESH)) u_dp (
    .clk(clk), .rstN(rstN), .clrFifo(clrFifo),
    .txWrEn(txWrEn), .txWrData(txWrData), .rxRdEn(rxRdEn),
    .strobe(strobe), .rxByteIn(engRxByte),
    .txHead(txHead), .txEmpty(txEmpty), .rxHead(rxRdData),
    .rxFull(rxFull), .rxValid(rxValid), .rxLevel(rxLevel), .evtData(evtData)
  );

  assign cmdKind = cmdKindE;

  always_comb begin
    statusWord          = '0;
    statusWord[BUSY_BIT] = busActive;
    statusWord[RXV_BIT]  = rxValid;
  end
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  parameter int LW    = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [1:0]       cmdKind,
  input logic             cmdNack,
  input logic [CNT_W-1:0] sizeLeft,
  input logic             sizeWrEn,
  input logic [LW-1:0]    rxLevel,
  input logic [15:0]      statusWord,
  input logic             evtComplete,
  input logic             evtNack,
  input logic             evtArbLost
);
  a_r6_read_needs_room: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 2'd2) |-> (rxLevel < LW'(DEPTH)));

  a_r6_last_read_nacked: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 2'd2) |-> (cmdNack == (sizeLeft == CNT_W'(1))));

  a_r5_count_steps_by_one: assert property (@(posedge clk) disable iff (!rstN)
    !sizeWrEn |=> (sizeLeft == $past(sizeLeft) || sizeLeft == $past(sizeLeft) - 1'b1));

  a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evtComplete, evtNack, evtArbLost}));

  a_r2_cmd_only_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> statusWord[8]);

  a_r11_no_cmd_after_arb: assert property (@(posedge clk) disable iff (!rstN)
    evtArbLost |-> !cmdValid && !statusWord[8]);
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .LW(LW)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdNack(cmdNack),
  .sizeLeft(sizeLeft), .sizeWrEn(sizeWrEn), .rxLevel(rxLevel), .statusWord(statusWord),
  .evtComplete(evtComplete), .evtNack(evtNack), .evtArbLost(evtArbLost)
);

// File: tb/test_i2c_xfer_seq.sv
module test_i2c_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic cfgMaster = 1, cfgDirRx = 0, cfgHold = 0, cfgAddr7 = 1, clrFifo = 0;
  logic addrWrEn = 0, sizeWrEn = 0, txWrEn = 0, rxRdEn = 0;
  logic [9:0] addrWrData = 0;
  logic [7:0] sizeWrData = 0, txWrData = 0, rxRdData, cmdByte, sizeLeft, engRxByte = 0;
  logic [1:0] cmdKind;
  logic cmdValid, cmdNack, engDone = 0, engNack = 0, engArbLost = 0;
  logic [15:0] statusWord;
  logic evtComplete, evtData, evtNack, evtArbLost;

  int nTests = 0, nFail = 0;
  int logQ[$], expQ[$];
  int cmdIdx = 0, injNackAt = -1, injArbAt = -1;
  int cntComp = 0, cntData = 0, cntNack = 0, cntArb = 0;
  logic [7:0] mq[$];
  logic expData = 0;
  int curKind = 0, lat = 0;
  bit pend = 0;
  logic [7:0] rxSeq = 8'h40;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_seq i_i2c_xfer_seq (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  // Bit-engine model: logs commands, answers with a done pulse two edges later
  always @(negedge clk) begin
    engDone = 0; engNack = 0; engArbLost = 0;
    if (pend) begin
      if (lat == 0) begin
        engDone = 1;
        engArbLost = (cmdIdx - 1 == injArbAt);
        engNack = (cmdIdx - 1 == injNackAt);
        engRxByte = rxSeq;
        if (curKind == 2) rxSeq = rxSeq + 8'd1;
        pend = 0;
      end else lat--;
    end
    if (cmdValid) begin
      logQ.push_back(int'(cmdKind) * 512 + ((cmdKind == 2'd2) ? int'(cmdNack) * 256 : 0)
                     + ((cmdKind == 2'd1) ? int'(cmdByte) : 0));
      curKind = int'(cmdKind);
      pend = 1; lat = 1; cmdIdx++;
    end
  end

  // Receive FIFO reference model, updated on the active edge
  always @(posedge clk) begin
    int prev;
    bit push, pop;
    if (!rstN) begin
      mq.delete(); expData = 0;
    end else begin
      prev = mq.size();
      push = engDone && curKind == 2 && !engArbLost;
      pop  = rxRdEn && prev > 0;
      if (clrFifo) begin
        mq.delete(); expData = 0;
      end else begin
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(engRxByte);
        expData = push && !pop && prev == 13;
      end
    end
  end

  // Per-clock comparison and event counting
  always @(negedge clk) begin
    if (rstN) begin
      if (evtComplete) cntComp++;
      if (evtData) cntData++;
      if (evtNack) cntNack++;
      if (evtArbLost) cntArb++;
      chk(statusWord[5] == (mq.size() != 0), "R6 rxValid", statusWord[5], mq.size() != 0);
      if (mq.size() != 0) chk(rxRdData == mq[0], "R6 rx order", rxRdData, mq[0]);
      chk(evtData == expData, "R7 evtData", evtData, expData);
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic doSize(input int v);
    sizeWrData = 8'(v); sizeWrEn = 1; tick(1); sizeWrEn = 0;
  endtask
  task automatic doAddr(input int a);
    addrWrData = 10'(a); addrWrEn = 1; tick(1); addrWrEn = 0;
  endtask
  task automatic pushTx(input int b);
    txWrData = 8'(b); txWrEn = 1; tick(1); txWrEn = 0;
  endtask
  task automatic pulseClr(); clrFifo = 1; tick(1); clrFifo = 0; endtask
  task automatic newTest();
    logQ.delete(); expQ.delete(); cmdIdx = 0;
    cntComp = 0; cntData = 0; cntNack = 0; cntArb = 0;
  endtask
  task automatic ex(input int kind, input int nack, input int b);
    expQ.push_back(kind * 512 + nack * 256 + b);
  endtask
  task automatic waitIdle();
    for (int g = 0; g < 3000 && statusWord[8]; g++) tick(1);
    tick(3);
  endtask
  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < 500 && !statusWord[5]; g++) tick(1);
      rxRdEn = 1; tick(1); rxRdEn = 0;
    end
  endtask
  task automatic cmpLog(input string tag);
    chk(logQ.size() == expQ.size(), {tag, " command count"}, logQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < logQ.size(); i++)
      chk(logQ[i] == expQ[i], {tag, " command"}, logQ[i], expQ[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    tick(5); rstN = 1; tick(1);
    // R1: reset state
    chk(statusWord == 16'h0, "R1 status", statusWord, 0);
    chk(!cmdValid && sizeLeft == 0, "R1 idle outputs", sizeLeft, 0);
    chk(!evtComplete && !evtNack && !evtArbLost && !evtData, "R1 events", 1, 0);

    // R3 R5 R8 R9: 7-bit transmit of three bytes
    newTest(); cfgDirRx = 0; cfgAddr7 = 1; cfgHold = 0;
    pushTx('h11); pushTx('h22); pushTx('h33); doSize(3); doAddr('h52);
    waitIdle();
    ex(0,0,0); ex(1,0,'hA4); ex(1,0,'h11); ex(1,0,'h22); ex(1,0,'h33); ex(3,0,0);
    cmpLog("R3 R5 tx7");
    chk(cntComp == 1, "R8 completion", cntComp, 1);
    chk(sizeLeft == 0, "R5 count", sizeLeft, 0);
    chk(statusWord == 0, "R9 bus released", statusWord, 0);

    // R6 R7 R2: receive 20 bytes, stall on full FIFO
    newTest(); cfgDirRx = 1; doSize(20); doAddr('h33);
    tick(150);
    chk(logQ.size() == 18, "R6 stall when full", logQ.size(), 18);
    chk(statusWord[8] == 1, "R6 bus kept during stall", statusWord[8], 1);
    chk(cntData == 1, "R7 threshold event", cntData, 1);
    doAddr('h7F); tick(20);
    chk(logQ.size() == 18, "R2 address ignored while busy", logQ.size(), 18);
    drain(20); waitIdle();
    ex(0,0,0); ex(1,0,'h67);
    for (int i = 0; i < 19; i++) ex(2,0,0);
    ex(2,1,0); ex(3,0,0);
    cmpLog("R6 rx20");
    chk(cntComp == 1, "R8 rx completion", cntComp, 1);

    // R4: 10-bit transmit
    newTest(); cfgDirRx = 0; cfgAddr7 = 0; pushTx('h5A); doSize(1); doAddr('h2A5);
    waitIdle();
    ex(0,0,0); ex(1,0,'hF4); ex(1,0,'hA5); ex(1,0,'h5A); ex(3,0,0);
    cmpLog("R4 tx10");

    // R4: 10-bit receive
    newTest(); cfgDirRx = 1; doSize(2); doAddr('h1C3);
    for (int g = 0; g < 300 && logQ.size() < 7; g++) tick(1);
    drain(2); waitIdle();
    ex(0,0,0); ex(1,0,'hF2); ex(1,0,'hC3); ex(0,0,0); ex(1,0,'hF3); ex(2,0,0); ex(2,1,0); ex(3,0,0);
    cmpLog("R4 rx10");

    // R9: hold keeps the bus, then repeated start
    newTest(); cfgAddr7 = 1; cfgDirRx = 0; cfgHold = 1; pushTx('h9C); doSize(1); doAddr('h10);
    for (int g = 0; g < 300 && cntComp == 0; g++) tick(1);
    tick(20);
    ex(0,0,0); ex(1,0,'h20); ex(1,0,'h9C);
    cmpLog("R9 held");
    chk(statusWord[8] == 1, "R9 bus stays active", statusWord[8], 1);
    newTest(); cfgDirRx = 1; cfgHold = 0; doSize(1); doAddr('h10);
    for (int g = 0; g < 300 && logQ.size() < 3; g++) tick(1);
    drain(1); waitIdle();
    ex(0,0,0); ex(1,0,'h21); ex(2,1,0); ex(3,0,0);
    cmpLog("R9 repeated start");
    chk(statusWord[8] == 0, "R9 released", statusWord[8], 0);

    // R10: NACK on a data byte, byte retained
    newTest(); cfgDirRx = 0; pushTx('h66); pushTx('h77); doSize(2); injNackAt = 2; doAddr('h05);
    waitIdle();
    ex(0,0,0); ex(1,0,'h0A); ex(1,0,'h66); ex(3,0,0);
    cmpLog("R10 nack");
    chk(cntNack == 1 && cntComp == 0, "R10 events", cntNack * 16 + cntComp, 16);
    chk(sizeLeft == 2, "R10 count kept", sizeLeft, 2);
    newTest(); injNackAt = -1; doAddr('h05); waitIdle();
    ex(0,0,0); ex(1,0,'h0A); ex(1,0,'h66); ex(1,0,'h77); ex(3,0,0);
    cmpLog("R10 byte retained");

    // R11 R12: arbitration loss, then FIFO clear
    newTest(); pushTx('h44); pushTx('h55); doSize(2); injArbAt = 2; doAddr('h05);
    waitIdle();
    ex(0,0,0); ex(1,0,'h0A); ex(1,0,'h44);
    cmpLog("R11 arb");
    chk(cntArb == 1 && cntComp == 0, "R11 event", cntArb, 1);
    chk(sizeLeft == 2 && statusWord[8] == 0, "R11 state", sizeLeft, 2);
    newTest(); injArbAt = -1; pulseClr(); pushTx('h99); doSize(1); doAddr('h05); waitIdle();
    ex(0,0,0); ex(1,0,'h0A); ex(1,0,'h99); ex(3,0,0);
    cmpLog("R12 tx cleared");

    // R2: no start outside master mode
    newTest(); cfgMaster = 0; doSize(1); doAddr('h05); tick(20);
    chk(logQ.size() == 0, "R2 not master", logQ.size(), 0);
    chk(statusWord[8] == 0, "R2 bus idle", statusWord[8], 0);
    cfgMaster = 1;

    // R12: receive FIFO cleared
    newTest(); cfgDirRx = 1; doSize(3); doAddr('h05); waitIdle();
    ex(0,0,0); ex(1,0,'h0B); ex(2,0,0); ex(2,0,0); ex(2,1,0); ex(3,0,0);
    cmpLog("R12 rx fill");
    chk(statusWord[5] == 1, "R12 rx holds data", statusWord[5], 1);
    pulseClr(); tick(1);
    chk(statusWord[5] == 0, "R12 rx cleared", statusWord[5], 0);

    // R8: zero-size transfer
    newTest(); cfgDirRx = 0; doSize(0); doAddr('h05); waitIdle();
    ex(0,0,0); ex(1,0,'h0A); ex(3,0,0);
    cmpLog("R8 zero size");
    chk(cntComp == 1, "R8 zero size completion", cntComp, 1);

    summary();
    $finish;
  end
endmodule